// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

This block is one DMA channel. It copies data from a source region to a destination region in beats of 8, 16 or 32 bits. It uses one word-addressed memory port that has a fixed read latency of one cycle. A transfer is described by a configuration word and two *end* addresses: the last source address and the last destination address. The engine works out each beat's address by stepping back from the end address by the number of beats still to come.

A job can be loaded straight from the ports, or fetched from memory as a four-word descriptor. The four words, at consecutive word addresses, are:

- the configuration word,
- the last source address,
- the last destination address,
- the link to the next descriptor.

When a descriptor finishes and its reload bit is set, the engine fetches the descriptor at the link address and carries on. This allows chains and rings, such as ping-pong buffering.

Trigger qualification is done by a separate block, which pulses `go`. Completion flags A and B and an error flag are sticky. The engine also reports busy and active status and the number of bytes still to move.

Top module: `dmaChannel`

## Requirements
- R1: A configuration is never acted on while its valid bit (bit 0) is 0. In that case neither `go` nor the start-now bit causes any memory write.
- R2: A valid configuration with start-now (bit 2) set begins moving data without `go`. With bit 2 clear, it waits with busy high and active low until `go` is pulsed.
- R3: Beat j of N (counting from 0) uses address end − step·(N−1−j). The step is 0, 1×, 2× or 4× the beat width for step codes 0, 1, 2 and 3. The source step code is in bits [13:12] and the destination step code is in bits [15:14].
- R4: The width code in bits [9:8] selects the beat width: 0 selects 1 byte, 1 selects 2 bytes and 2 selects 4 bytes. Writes enable only the lanes of the beat, starting at the destination byte offset, and carry the source bytes in order.
- R5: Bits [25:16] hold the beat count minus one. `remainBytes` equals the beats still to move times the width in bytes, and it reads 0 after reset.
- R6: `fetchStart` reads the four descriptor words at `fetchAddr`. At the end of a descriptor whose reload bit (bit 1) is set, the engine fetches the descriptor at the link address and continues. This works for straight chains and for rings.
- R7: At the end of a descriptor, bit 4 sets `intA` and bit 5 sets `intB`. The flags hold until `flagClr` clears them: bit 0 clears A, bit 1 clears B and bit 2 clears the error flag.
- R8: A source or destination end address that is not a multiple of the width, or a link address that is not a multiple of 16, sets `errFlag`. The engine then goes idle with no write.
- R9: `busy` is high from a start until the last descriptor without reload completes. `active` is high only while fetching or moving data. Neither memory strobe is asserted while idle.
- R10: `abort` returns the engine to idle no later than one cycle after the beat in flight completes, and it leaves the flags unchanged.
- R11: `descLoad` and `fetchStart` are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| descLoad | input | 1 | Load a descriptor from the ports below |
| descCfg | input | 32 | Configuration word for a direct load |
| descSrcEnd | input | AW | Last source byte address |
| descDstEnd | input | AW | Last destination byte address |
| descLink | input | AW | Next descriptor byte address |
| fetchStart | input | 1 | Start by fetching a descriptor from memory |
| fetchAddr | input | AW | Byte address of the head descriptor |
| go | input | 1 | Qualified trigger from the trigger block |
| abort | input | 1 | Stop after the beat in flight |
| flagClr | input | 3 | Clear strobes for A, B and error |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | AW-2 | Word address |
| memBe | output | 4 | Byte-lane enables for writes |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid one cycle after `memRe` |
| intA | output | 1 | Completion flag A |
| intB | output | 1 | Completion flag B |
| errFlag | output | 1 | Alignment error flag |
| active | output | 1 | Engine is fetching or moving data |
| busy | output | 1 | A job is pending or running |
| remainBytes | output | CNT_W+3 | Bytes left in the current descriptor |

## Verification
The bench sweeps every combination of width, source step and destination step for one-beat and three-beat jobs. It compares the address, lane enables and bytes of every write against values it computes from the end-address formula. A design that counted forward from the end address, or that mis-scaled the 4× step code, would write to the wrong words. A design that shifted data into the wrong lane would fail the per-byte comparison.

Chained and ring descriptors show whether the link is followed in order, and whether the words of the next descriptor are taken in their correct positions. Further cases cover a configuration without the valid bit, misaligned end addresses and links, start requests issued while busy, and an abort in the middle of a ring. These expose an engine that runs when it should not, writes after an error, or keeps going after an abort.

// File: rtl/dmaChanPkg.sv
package dmaChanPkg;

  // Configuration word field positions
  localparam int CFG_VALID  = 0;
  localparam int CFG_RELOAD = 1;
  localparam int CFG_START  = 2;
  localparam int CFG_SETA   = 4;
  localparam int CFG_SETB   = 5;
  localparam int CFG_WIDTH  = 8;   // [9:8]
  localparam int CFG_SINC   = 12;  // [13:12]
  localparam int CFG_DINC   = 14;  // [15:14]
  localparam int CFG_CNT    = 16;  // count-1 starts here

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_RD, S_WR
  } dmaState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadDirect;
    logic       loadLink;
    logic       fetchCap;
    logic [1:0] capIdx;
    logic       descRd;
    logic [1:0] rdIdx;
    logic       srcRd;
    logic       dstWr;
    logic       beatDone;
    logic       setDone;
    logic       setErr;
  } dmaStrobe_t;

  // log2 of beat width in bytes
  function automatic logic [1:0] widthLog(input logic [1:0] code);
    return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
  endfunction

  // log2 of step multiplier for non-zero step codes
  function automatic logic [1:0] stepLog(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : (code == 2'd2) ? 2'd1 : 2'd0;
  endfunction

endpackage

// File: rtl/dmaChanCtrl.sv
module dmaChanCtrl
  import dmaChanPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descLoad,
  input  logic       fetchStart,
  input  logic       go,
  input  logic       abort,
  input  logic       cfgValid,
  input  logic       cfgStart,
  input  logic       cfgReload,
  input  logic       misaligned,
  input  logic       linkMisaligned,
  input  logic       lastBeat,
  output dmaStrobe_t st,
  output logic       active,
  output logic       busy
);

  dmaState_t state, nextState;
  logic [2:0] k, kNext;
  logic       abortHold;

  always_comb begin
    st = '0;
    nextState = state;
    kNext = k;
    unique case (state)
      S_IDLE: begin
        if (descLoad) begin
          st.loadDirect = 1'b1;
          nextState = S_WAIT;
        end else if (fetchStart) begin
          st.loadLink = 1'b1;
          nextState = S_FETCH;
          kNext = 3'd0;
        end
      end
      S_FETCH: begin
        if (abort) begin
          nextState = S_IDLE;
        end else if (k == 3'd0 && linkMisaligned) begin
          st.setErr = 1'b1;
          nextState = S_IDLE;
        end else begin
          if (k < 3'd4) begin
            st.descRd = 1'b1;
            st.rdIdx  = k[1:0];
          end
          if (k != 3'd0) begin
            st.fetchCap = 1'b1;
            st.capIdx   = 2'(k - 3'd1);
          end
          if (k == 3'd4) nextState = S_WAIT;
          else kNext = k + 3'd1;
        end
      end
      S_WAIT: begin
        if (abort) begin
          nextState = S_IDLE;
        end else if (cfgValid && (cfgStart || go)) begin
          if (misaligned) begin
            st.setErr = 1'b1;
            nextState = S_IDLE;
          end else begin
            nextState = S_RD;
          end
        end
      end
      S_RD: begin
        st.srcRd = 1'b1;
        nextState = S_WR;
      end
      S_WR: begin
        st.dstWr = 1'b1;
        st.beatDone = 1'b1;
        st.setDone = lastBeat;
        if (abort || abortHold) nextState = S_IDLE;
        else if (!lastBeat) nextState = S_RD;
        else if (cfgReload) begin
          nextState = S_FETCH;
          kNext = 3'd0;
        end else nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      k <= 3'd0;
      abortHold <= 1'b0;
    end else begin
      state <= nextState;
      k <= kNext;
      if (state == S_IDLE) abortHold <= 1'b0;
      else if (abort) abortHold <= 1'b1;
    end
  end

  assign busy   = (state != S_IDLE);
  assign active = (state == S_FETCH) || (state == S_RD) || (state == S_WR);

endmodule

// File: rtl/dmaChanDatapath.sv
module dmaChanDatapath
  import dmaChanPkg::*;
#(
  parameter int AW    = 16,
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        st,
  input  logic [31:0]       descCfg,
  input  logic [AW-1:0]     descSrcEnd,
  input  logic [AW-1:0]     descDstEnd,
  input  logic [AW-1:0]     descLink,
  input  logic [AW-1:0]     fetchAddr,
  input  logic [2:0]        flagClr,
  input  logic [31:0]       memRdata,
  output logic              memRe,
  output logic              memWe,
  output logic [AW-3:0]     memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  output logic              cfgValid,
  output logic              cfgStart,
  output logic              cfgReload,
  output logic              misaligned,
  output logic              linkMisaligned,
  output logic              lastBeat,
  output logic [2:0]        flags,
  output logic [CNT_W+2:0]  remainBytes
);

  localparam int LW = CNT_W + 1;

  logic [31:0]   cfgReg;
  logic [AW-1:0] srcEnd, dstEnd, linkReg;
  logic [LW-1:0] xferLeft;

  logic [1:0] wCode, sCode, dCode, wLog;
  logic [2:0] sShift, dShift;
  logic [LW-1:0] remAfter;
  logic [AW-1:0] srcAddr, dstAddr;
  logic [1:0] wMask;
  logic [3:0] laneMask;
  logic [31:0] rdShift;
  logic cfgUnused;

  assign wCode = cfgReg[CFG_WIDTH +: 2];
  assign sCode = cfgReg[CFG_SINC +: 2];
  assign dCode = cfgReg[CFG_DINC +: 2];
  assign wLog  = widthLog(wCode);
  assign sShift = {1'b0, wLog} + {1'b0, stepLog(sCode)};
  assign dShift = {1'b0, wLog} + {1'b0, stepLog(dCode)};
  assign remAfter = xferLeft - LW'(1);

  // Count back from the end address by the beats still to come
  assign srcAddr = (sCode == 2'd0) ? srcEnd : srcEnd - (AW'(remAfter) << sShift);
  assign dstAddr = (dCode == 2'd0) ? dstEnd : dstEnd - (AW'(remAfter) << dShift);

  assign wMask = (wLog == 2'd0) ? 2'b00 : (wLog == 2'd1) ? 2'b01 : 2'b11;
  assign misaligned = |(srcEnd[1:0] & wMask) || |(dstEnd[1:0] & wMask);
  assign linkMisaligned = |linkReg[3:0];
  assign lastBeat = (xferLeft == LW'(1));

  assign cfgValid  = cfgReg[CFG_VALID];
  assign cfgStart  = cfgReg[CFG_START];
  assign cfgReload = cfgReg[CFG_RELOAD];
  assign cfgUnused = ^{cfgReg[31:CFG_CNT+CNT_W], cfgReg[11:10], cfgReg[7:6], cfgReg[3]};

  assign laneMask = (wLog == 2'd0) ? 4'h1 : (wLog == 2'd1) ? 4'h3 : 4'hF;
  assign rdShift  = memRdata >> {srcAddr[1:0], 3'b000};

  assign memRe    = st.descRd | st.srcRd;
  assign memWe    = st.dstWr;
  assign memBe    = laneMask << dstAddr[1:0];
  assign memWdata = rdShift << {dstAddr[1:0], 3'b000};

  always_comb begin
    if (st.descRd)     memAddr = linkReg[AW-1:2] + (AW-2)'(st.rdIdx);
    else if (st.srcRd) memAddr = srcAddr[AW-1:2];
    else               memAddr = dstAddr[AW-1:2];
  end

  assign remainBytes = (CNT_W+3)'(xferLeft) << wLog;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      srcEnd   <= '0;
      dstEnd   <= '0;
      linkReg  <= '0;
      xferLeft <= '0;
      flags    <= '0;
    end else begin
      if (st.loadDirect) begin
        cfgReg   <= descCfg;
        srcEnd   <= descSrcEnd;
        dstEnd   <= descDstEnd;
        linkReg  <= descLink;
        xferLeft <= LW'(descCfg[CFG_CNT +: CNT_W]) + LW'(1);
      end else if (st.loadLink) begin
        linkReg <= fetchAddr;
      end else if (st.fetchCap) begin
        unique case (st.capIdx)
          2'd0: begin
            cfgReg   <= memRdata;
            xferLeft <= LW'(memRdata[CFG_CNT +: CNT_W]) + LW'(1);
          end
          2'd1: srcEnd  <= memRdata[AW-1:0];
          2'd2: dstEnd  <= memRdata[AW-1:0];
          default: linkReg <= memRdata[AW-1:0];
        endcase
      end else if (st.beatDone) begin
        xferLeft <= xferLeft - LW'(1);
      end
      flags <= (flags & ~flagClr)
             | {st.setErr,
                st.setDone & cfgReg[CFG_SETB],
                st.setDone & cfgReg[CFG_SETA]};
    end
  end

endmodule

// File: rtl/dmaChannel.sv
module dmaChannel
  import dmaChanPkg::*;
#(
  parameter int AW    = 16,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             descLoad,
  input  logic [31:0]      descCfg,
  input  logic [AW-1:0]    descSrcEnd,
  input  logic [AW-1:0]    descDstEnd,
  input  logic [AW-1:0]    descLink,
  input  logic             fetchStart,
  input  logic [AW-1:0]    fetchAddr,
  input  logic             go,
  input  logic             abort,
  input  logic [2:0]       flagClr,
  output logic             memRe,
  output logic             memWe,
  output logic [AW-3:0]    memAddr,
  output logic [3:0]       memBe,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  output logic             intA,
  output logic             intB,
  output logic             errFlag,
  output logic             active,
  output logic             busy,
  output logic [CNT_W+2:0] remainBytes
);

  dmaStrobe_t st;
  logic cfgValid, cfgStart, cfgReload, misaligned, linkMisaligned, lastBeat;
  logic [2:0] flags;

  dmaChanCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .descLoad(descLoad), .fetchStart(fetchStart),
    .go(go), .abort(abort), .cfgValid(cfgValid), .cfgStart(cfgStart),
    .cfgReload(cfgReload), .misaligned(misaligned),
    .linkMisaligned(linkMisaligned), .lastBeat(lastBeat),
    .st(st), .active(active), .busy(busy)
  );

  dmaChanDatapath #(.AW(AW), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .descCfg(descCfg),
    .descSrcEnd(descSrcEnd), .descDstEnd(descDstEnd), .descLink(descLink),
    .fetchAddr(fetchAddr), .flagClr(flagClr), .memRdata(memRdata),
    .memRe(memRe), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .cfgValid(cfgValid), .cfgStart(cfgStart),
    .cfgReload(cfgReload), .misaligned(misaligned),
    .linkMisaligned(linkMisaligned), .lastBeat(lastBeat),
    .flags(flags), .remainBytes(remainBytes)
  );

  assign intA    = flags[0];
  assign intB    = flags[1];
  assign errFlag = flags[2];

endmodule

// File: rtl/dmaChanChecker.sv
module dmaChanChecker (
  input logic       clk,
  input logic       rstN,
  input logic       abort,
  input logic [2:0] flagClr,
  input logic       memRe,
  input logic       memWe,
  input logic [3:0] memBe,
  input logic       intA,
  input logic       intB,
  input logic       errFlag,
  input logic       active,
  input logic       busy
);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRe && !memWe));

  assert_active_in_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    active |-> busy);

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  assert_lane_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(memBe) == 1 || $countones(memBe) == 2 || $countones(memBe) == 4));

  assert_flag_a_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intA && !flagClr[0]) |=> intA);

  assert_flag_b_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intB && !flagClr[1]) |=> intB);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !flagClr[2]) |=> errFlag);

  assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rstN)
    (abort && busy && !memRe) |=> !active);

endmodule

bind dmaChannel dmaChanChecker u_chk (
  .clk(clk), .rstN(rstN), .abort(abort), .flagClr(flagClr),
  .memRe(memRe), .memWe(memWe), .memBe(memBe), .intA(intA), .intB(intB),
  .errFlag(errFlag), .active(active), .busy(busy)
);

// File: tb/tb_dmaChannel.sv
`timescale 1ns/1ps
module tb_dmaChannel;
  localparam int AW = 16;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic descLoad = 0, fetchStart = 0, go = 0, abort = 0;
  logic [31:0] descCfg = 0;
  logic [AW-1:0] descSrcEnd = 0, descDstEnd = 0, descLink = 0, fetchAddr = 0;
  logic [2:0] flagClr = 0;
  logic memRe, memWe, intA, intB, errFlag, active, busy;
  logic [AW-3:0] memAddr;
  logic [3:0] memBe;
  logic [31:0] memWdata, memRdata;
  logic [CNT_W+2:0] remainBytes;

  dmaChannel #(.AW(AW), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .descLoad(descLoad), .descCfg(descCfg),
    .descSrcEnd(descSrcEnd), .descDstEnd(descDstEnd), .descLink(descLink),
    .fetchStart(fetchStart), .fetchAddr(fetchAddr), .go(go), .abort(abort),
    .flagClr(flagClr), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata), .intA(intA),
    .intB(intB), .errFlag(errFlag), .active(active), .busy(busy),
    .remainBytes(remainBytes)
  );

  // Memory model plus write recorder
  logic [31:0] mem [0:2047];
  logic [31:0] rdReg;
  logic bwEn = 0;
  logic [10:0] bwAddr = 0;
  logic [31:0] bwData = 0;
  int wrCnt = 0;
  logic [AW-3:0] wrA [0:255];
  logic [3:0]    wrB [0:255];
  logic [31:0]   wrD [0:255];
  assign memRdata = rdReg;

  function automatic logic [7:0] byteAt(input int b);
    return 8'((b >> 2) + 17 * ((b & 3) + 1));
  endfunction

  function automatic logic [31:0] srcWord(input int w);
    return {byteAt(4*w+3), byteAt(4*w+2), byteAt(4*w+1), byteAt(4*w)};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < 2048; w++) mem[w] <= srcWord(w);
      rdReg <= '0;
    end else begin
      if (bwEn) mem[bwAddr] <= bwData;
      if (memRe) rdReg <= mem[memAddr[10:0]];
      if (memWe) begin
        for (int k = 0; k < 4; k++)
          if (memBe[k]) mem[memAddr[10:0]][8*k +: 8] <= memWdata[8*k +: 8];
        wrA[wrCnt[7:0]] <= memAddr;
        wrB[wrCnt[7:0]] <= memBe;
        wrD[wrCnt[7:0]] <= memWdata;
        wrCnt <= wrCnt + 1;
      end
    end
  end

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 600; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  task automatic poke(input int byteAddr, input logic [31:0] v);
    @(negedge clk);
    bwEn = 1; bwAddr = 11'(byteAddr >> 2); bwData = v;
    @(negedge clk);
    bwEn = 0;
  endtask

  task automatic clearFlags();
    @(negedge clk); flagClr = 3'b111;
    @(negedge clk); flagClr = 3'b000;
  endtask

  task automatic loadDesc(input logic [31:0] c, input int s, input int d, input int l);
    descLoad = 1; descCfg = c;
    descSrcEnd = AW'(s); descDstEnd = AW'(d); descLink = AW'(l);
    @(negedge clk);
    descLoad = 0;
  endtask

  task automatic runCase(input int w, input int si, input int di, input int n, input bit trig);
    int wb, ss, ds, sEnd, dEnd, base, idx, s, d, lane;
    bit setA, setB, ok;
    logic [31:0] c;
    wb = 1 << w;
    ss = (si == 0) ? 0 : (wb << ((si == 3) ? 2 : si - 1));
    ds = (di == 0) ? 0 : (wb << ((di == 3) ? 2 : di - 1));
    sEnd = 'h400 + ss * (n - 1);
    dEnd = 'h1000 + ds * (n - 1);
    setA = ((si + di) % 2) == 0;
    setB = ((w + n) % 2) == 1;
    c = 32'h1 | (32'(trig) << 2) | (32'(setA) << 4) | (32'(setB) << 5)
      | (32'(w) << 8) | (32'(si) << 12) | (32'(di) << 14) | (32'(n - 1) << 16);
    clearFlags();
    base = wrCnt;
    loadDesc(c, sEnd, dEnd, 0);
    chk(remainBytes == (CNT_W+3)'(n * wb), "R5 remaining bytes after load", remainBytes, n * wb);
    if (!trig) begin
      repeat (3) @(negedge clk);
      chk(busy && !active && wrCnt == base, "R2 waits for go", {busy, active}, 2'b10);
      go = 1;
      @(negedge clk);
      go = 0;
      chk(active, "R9 active while moving", active, 1);
    end
    waitIdle();
    chk(!busy && !active, "R9 idle after last descriptor", {busy, active}, 0);
    chk(wrCnt - base == n, "R5 beat count", wrCnt - base, n);
    for (int j = 0; j < n; j++) begin
      idx = (base + j) % 256;
      s = 'h400 + j * ss;
      d = 'h1000 + j * ds;
      chk(wrA[idx] == (AW-2)'(d >> 2), "R3 destination word address", wrA[idx], d >> 2);
      chk(wrB[idx] == 4'(((1 << wb) - 1) << (d & 3)), "R4 lane enables", wrB[idx],
          ((1 << wb) - 1) << (d & 3));
      ok = 1;
      for (int q = 0; q < wb; q++) begin
        lane = (d & 3) + q;
        if (wrD[idx][8*lane +: 8] != byteAt(s + q)) ok = 0;
      end
      chk(ok, "R3 R4 beat data from source address", wrD[idx], byteAt(s));
    end
    chk(intA == setA && intB == setB, "R7 completion flags", {intB, intA}, {setB, setA});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, snap;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !active && !intA && !intB && !errFlag && remainBytes == 0,
        "R5 R9 reset state", {busy, active, intA, intB, errFlag}, 0);

    // Sweep width, steps, count and start mode
    for (int w = 0; w < 3; w++)
      for (int si = 0; si < 4; si++)
        for (int di = 0; di < 4; di++)
          for (int n = 1; n <= 3; n += 2)
            runCase(w, si, di, n, ((w + si + di + n) % 2) == 0);

    // R1: invalid config never runs; R11: load while busy ignored
    clearFlags();
    base = wrCnt;
    loadDesc(32'h0001_5204, 'h404, 'h1004, 0);
    go = 1; @(negedge clk); go = 0;
    repeat (8) @(negedge clk);
    chk(wrCnt == base && busy && !active, "R1 invalid config not acted on", wrCnt - base, 0);
    loadDesc(32'h0000_0205, 'h400, 'h1000, 0);
    repeat (6) @(negedge clk);
    chk(wrCnt == base, "R11 load while busy ignored", wrCnt - base, 0);
    abort = 1; @(negedge clk); abort = 0;
    @(negedge clk);
    chk(!busy, "R10 abort from waiting", busy, 0);

    // R8: misaligned source end address
    clearFlags();
    base = wrCnt;
    loadDesc(32'h0000_0205, 'h402, 'h1000, 0);
    repeat (4) @(negedge clk);
    chk(errFlag && !busy && wrCnt == base, "R8 misaligned source", {errFlag, busy}, 2'b10);
    clearFlags();
    chk(!errFlag, "R7 flag clear", errFlag, 0);

    // R8: misaligned link for a fetch
    @(negedge clk);
    fetchStart = 1; fetchAddr = AW'('h208);
    @(negedge clk);
    fetchStart = 0;
    repeat (4) @(negedge clk);
    chk(errFlag && !busy && wrCnt == base, "R8 misaligned link", {errFlag, busy}, 2'b10);

    // R6: two-descriptor chain
    poke('h200, 32'h0001_5237); poke('h204, 'h444); poke('h208, 'h1104); poke('h20C, 'h210);
    poke('h210, 32'h0002_5225); poke('h214, 'h488); poke('h218, 'h1118); poke('h21C, 0);
    clearFlags();
    base = wrCnt;
    @(negedge clk);
    fetchStart = 1; fetchAddr = AW'('h200);
    @(negedge clk);
    fetchStart = 0;
    waitIdle();
    chk(wrCnt - base == 5, "R6 chain beat count", wrCnt - base, 5);
    begin
      int dw [5] = '{'h440, 'h441, 'h444, 'h445, 'h446};
      int sw [5] = '{'h110, 'h111, 'h120, 'h121, 'h122};
      for (int j = 0; j < 5; j++) begin
        chk(wrA[(base+j)%256] == (AW-2)'(dw[j]), "R6 chain write address", wrA[(base+j)%256], dw[j]);
        chk(wrD[(base+j)%256] == srcWord(sw[j]), "R6 chain write data", wrD[(base+j)%256], srcWord(sw[j]));
      end
    end
    chk(intA && intB && !busy, "R7 flags from both descriptors", {intB, intA}, 2'b11);

    // R6 ring then R10 abort
    poke('h220, 32'h0000_0217); poke('h224, 'h500); poke('h228, 'h1200); poke('h22C, 'h230);
    poke('h230, 32'h0000_0217); poke('h234, 'h504); poke('h238, 'h1200); poke('h23C, 'h220);
    clearFlags();
    base = wrCnt;
    @(negedge clk);
    fetchStart = 1; fetchAddr = AW'('h220);
    @(negedge clk);
    fetchStart = 0;
    for (int i = 0; i < 500; i++) begin
      if (wrCnt - base >= 5) break;
      @(negedge clk);
    end
    chk(wrCnt - base >= 5, "R6 ring keeps going", wrCnt - base, 5);
    chk(wrD[base%256] == srcWord('h140) && wrD[(base+1)%256] == srcWord('h141),
        "R6 ring alternates descriptors", wrD[(base+1)%256], srcWord('h141));
    abort = 1; @(negedge clk); abort = 0;
    repeat (2) @(negedge clk);
    chk(!busy, "R10 abort ends ring", busy, 0);
    snap = wrCnt;
    repeat (10) @(negedge clk);
    chk(wrCnt == snap, "R10 no writes after abort", wrCnt - snap, 0);
    chk(intA && !errFlag, "R10 flags unchanged by abort", {errFlag, intA}, 2'b01);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule